// File: doc/BRIEF.md
# Limit-Match Interval Counter-Timer

This block is a single counter-timer. It is reached through a word-addressed register port and has one level-sensitive interrupt. A prescaler divides the system clock into a tick every 500 ns. Each tick advances a 22-bit count that sits in bits 30:9 of a 32-bit word, so bits 8:0 always read as zero. Software programs a limit. When the count reaches a nonzero limit, the block sets a sticky flag in bit 31 and raises the interrupt. On the next tick the count wraps to zero, so the interrupt comes back once per period for as long as it is not serviced. To acknowledge, software reads the limit word. A zero limit makes the count run freely over its whole range without any event.

The register port carries requests as a stream. A request moves when `req_valid` and `req_ready` are both high on a clock edge. A read returns one response word on `rsp_valid`/`rsp_rdata` in the following cycle. That response stays in place until `rsp_ready` takes it. While a response is stalled, `req_ready` is low, so the port never holds more than one read in flight. Writes produce no response. Every access is a full 32-bit word, and there are no byte enables.

Top module: `ctm_limit_timer`

## Requirements
- R1: After reset the limit, count and reached flag are zero, the interrupt is low, and the count runs in free-run mode with `req_ready` high and `rsp_valid` low.
- R2: The count field (bits 30:9) goes up by one every CLKS_PER_TICK clocks, and bits 8:0 of the count word always read zero.
- R3: A write to word 0 (byte address 0x00) stores bits 30:9 of the write data as the limit, restarts the count and the prescaler from zero, and drops the interrupt in the same edge.
- R4: A write to word 2 (byte address 0x08) stores the limit with the same masking. The count keeps running undisturbed and the interrupt does not change.
- R5: In the edge where the count takes the value of a nonzero limit, bit 31 (reached) and the interrupt go high. The next tick reloads the count to zero, so the event repeats every limit+1 ticks.
- R6: A read of word 0 returns the limit in bits 30:9 with bit 31 zero. The same edge clears the reached flag and the interrupt, unless a match falls in that edge, in which case the match wins.
- R7: A read of word 1 (byte address 0x04) returns the reached flag in bit 31 and the count in bits 30:9. It changes nothing.
- R8: With a limit of zero the count wraps from 0x7FFFFE00 to zero, and neither the reached flag nor the interrupt is ever set.
- R9: Reads of any word other than 0 and 1 return zero. Writes to any word other than 0 and 2 are ignored.
- R10: A read accepted in one edge shows `rsp_valid` after that edge. The response and its data hold until `rsp_ready` is high at an edge, and `req_ready` stays low while a response waits. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; word index is bits ADDR_W-1:2 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response consumer accepts |
| rsp_rdata | output | 32 | Read response data |
| irq | output | 1 | Level interrupt on limit match |

## Verification
A request driven at the falling edge of cycle E is taken at edge E+1. Its response carries the state as it stood after edge E and becomes visible at the falling edge that follows E+1. The bench therefore computes each expected word at the moment it drives the request and queues it for the monitor. The count is modelled as floor((E − k0)/CLKS_PER_TICK) ticks since the restart edge k0. A match therefore lands exactly at edge k0 + limit·CLKS_PER_TICK, and the interrupt is sampled one falling edge before and one after it. Reads and acknowledges are placed in the middle of a tick period, so no request shares an edge with a tick or a match.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int DATA_W    = 32;
  localparam int FIELD_LSB = 9;
  localparam int CNT_W     = DATA_W - 1 - FIELD_LSB;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    SEL_LIMIT      = 2'd0,
    SEL_COUNT      = 2'd1,
    SEL_LIMIT_KEEP = 2'd2,
    SEL_NONE       = 2'd3
  } sel_e;

  function automatic logic [DATA_W-1:0] place_field(input logic flag, input cnt_t v);
    return {flag, v, {FIELD_LSB{1'b0}}};
  endfunction

  function automatic cnt_t take_field(input logic [DATA_W-1:0] w);
    return w[DATA_W-2:FIELD_LSB];
  endfunction
endpackage

// File: rtl/ctm_prescale.sv
module ctm_prescale #(
  parameter int CLKS_PER_TICK = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  generate
    if (CLKS_PER_TICK <= 1) begin : g_direct
      logic unused_direct;
      assign unused_direct = ^{clk, rst_n, restart};
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PRE_W = $clog2(CLKS_PER_TICK);
      localparam logic [PRE_W-1:0] LAST = PRE_W'(CLKS_PER_TICK - 1);
      logic [PRE_W-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else if (restart || pre_q == LAST) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end

      assign tick = (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/ctm_core.sv
module ctm_core
  import ctm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic lim_wr,
  input  cnt_t lim_val,
  input  logic ack,
  output cnt_t cnt,
  output cnt_t lim,
  output logic reached,
  output logic irq
);
  cnt_t cnt_q, lim_q, cnt_d;
  logic rch_q, irq_q;
  logic at_lim, hit;

  assign at_lim = (lim_q != '0) && (cnt_q == lim_q);
  assign cnt_d  = at_lim ? '0 : cnt_q + 1'b1;
  assign hit    = tick && !restart && (lim_q != '0) && (cnt_d == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
    end else if (lim_wr) begin
      lim_q <= lim_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rch_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (hit) begin
        rch_q <= 1'b1;
      end else if (ack) begin
        rch_q <= 1'b0;
      end
      if (hit) begin
        irq_q <= 1'b1;
      end else if (ack || restart) begin
        irq_q <= 1'b0;
      end
    end
  end

  assign cnt     = cnt_q;
  assign lim     = lim_q;
  assign reached = rch_q;
  assign irq     = irq_q;
endmodule

// File: rtl/ctm_regif.sv
module ctm_regif
  import ctm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  cnt_t              cnt,
  input  cnt_t              lim,
  input  logic              reached,
  output logic              restart,
  output logic              lim_wr,
  output cnt_t              lim_val,
  output logic              ack
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  sel_e              sel;
  logic              acc;
  logic [DATA_W-1:0] rd_mux;
  logic              rv_q;
  logic [DATA_W-1:0] rd_q;
  logic              unused_bits;

  assign word = req_addr[ADDR_W-1:2];
  assign unused_bits = ^{req_addr[1:0], req_wdata[DATA_W-1], req_wdata[FIELD_LSB-1:0]};

  always_comb begin
    if (word == WORD_W'(0))      sel = SEL_LIMIT;
    else if (word == WORD_W'(1)) sel = SEL_COUNT;
    else if (word == WORD_W'(2)) sel = SEL_LIMIT_KEEP;
    else                         sel = SEL_NONE;
  end

  assign req_ready = !rv_q || rsp_ready;
  assign acc       = req_valid && req_ready;

  assign restart = acc && req_write && (sel == SEL_LIMIT);
  assign lim_wr  = acc && req_write && (sel == SEL_LIMIT || sel == SEL_LIMIT_KEEP);
  assign lim_val = take_field(req_wdata);
  assign ack     = acc && !req_write && (sel == SEL_LIMIT);

  always_comb begin
    case (sel)
      SEL_LIMIT: rd_mux = place_field(1'b0, lim);
      SEL_COUNT: rd_mux = place_field(reached, cnt);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else if (acc && !req_write) begin
      rv_q <= 1'b1;
      rd_q <= rd_mux;
    end else if (rsp_ready) begin
      rv_q <= 1'b0;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;
endmodule

// File: rtl/ctm_limit_timer.sv
module ctm_limit_timer
  import ctm_pkg::*;
#(
  parameter int CLKS_PER_TICK = 25,
  parameter int ADDR_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              irq
);
  logic tick_w, restart_w, lim_wr_w, ack_w, rch_w;
  cnt_t cnt_w, lim_w, lim_val_w;

  ctm_prescale #(.CLKS_PER_TICK(CLKS_PER_TICK)) i_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart_w), .tick(tick_w)
  );

  ctm_regif #(.ADDR_W(ADDR_W)) i_regif (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cnt(cnt_w), .lim(lim_w), .reached(rch_w),
    .restart(restart_w), .lim_wr(lim_wr_w), .lim_val(lim_val_w), .ack(ack_w)
  );

  ctm_core i_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .restart(restart_w),
    .lim_wr(lim_wr_w), .lim_val(lim_val_w), .ack(ack_w),
    .cnt(cnt_w), .lim(lim_w), .reached(rch_w), .irq(irq)
  );
endmodule

// File: rtl/ctm_limit_timer_chk.sv
module ctm_limit_timer_chk
  import ctm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              irq,
  input cnt_t              cnt_w,
  input cnt_t              lim_w
);
  logic take0;
  assign take0 = req_valid && req_ready && (req_addr[ADDR_W-1:2] == '0);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_w == $past(cnt_w) || cnt_w == $past(cnt_w) + 1'b1 || cnt_w == '0));

  assert_irq_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (lim_w != '0 && cnt_w == lim_w));

  assert_free_run_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_w == '0 && !irq) |=> !irq);

  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take0 && req_write) |=> (!irq && cnt_w == '0));

  assert_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take0 && !req_write) |=> (!irq || cnt_w == lim_w));
endmodule

bind ctm_limit_timer ctm_limit_timer_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_ctm_limit_timer.sv
module test_ctm_limit_timer;
  localparam int N    = 25;
  localparam int AW   = 5;
  localparam int HALF = N / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  ctm_limit_timer #(.CLKS_PER_TICK(N), .ADDR_W(AW)) i_ctm_limit_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  int k0 = 0, lim = 0, ack_k = 0;

  function automatic int e_cnt(int e);
    int t = (e - k0) / N;
    return (lim == 0) ? t : t % (lim + 1);
  endfunction

  function automatic bit e_rch(int e);
    int first, p, lm;
    if (lim == 0) return 1'b0;
    first = k0 + lim * N;
    if (e < first) return 1'b0;
    p  = (lim + 1) * N;
    lm = first + ((e - first) / p) * p;
    return lm >= ack_k;
  endfunction

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_to(int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic wr(int idx, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(idx * 4); req_wdata = d;
    if (idx == 0) begin
      k0 = cyc + 1; ack_k = cyc + 1; lim = int'(d[30:9]);
    end else if (idx == 2) begin
      lim = int'(d[30:9]);
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(int idx, string tag);
    logic [31:0] exp;
    if (idx == 0) begin
      exp = 32'(lim) << 9;
      ack_k = cyc + 1;
    end else if (idx == 1) begin
      exp = (e_rch(cyc) ? 32'h8000_0000 : 32'h0) | (32'(e_cnt(cyc)) << 9);
    end else begin
      exp = 32'h0;
    end
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(idx * 4);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_irq(string tag);
    check_eq(tag, {31'b0, irq}, {31'b0, e_rch(cyc)});
  endtask

  always begin
    @(negedge clk);
    #1;
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check_eq("R10 unexpected response", rsp_rdata, 32'hxxxx_xxxx);
      end else begin
        check_eq(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    k0 = cyc; ack_k = cyc; lim = 0;
    check_eq("R1 irq after reset", {31'b0, irq}, 32'h0);
    check_eq("R1 req_ready after reset", {31'b0, req_ready}, 32'h1);
    check_eq("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    rd(0, "R1 limit after reset");
    rd(1, "R1 count after reset");
    wait_to(k0 + 5 * N + HALF);
    rd(1, "R2 R8 free-run count");
    check_irq("R8 no irq in free-run");

    // R3: masked limit of 3 units, restart
    wr(0, 32'h8000_07FF);
    rd(0, "R3 masked limit readback");
    wait_to(k0 + 2 * N + HALF);
    rd(1, "R2 count after two ticks");
    wait_to(k0 + 3 * N - 1);
    check_irq("R5 irq low before match");
    @(negedge clk);
    check_irq("R5 irq high at match edge");
    wait_to(k0 + 3 * N + HALF);
    rd(1, "R5 R7 count at limit with reached");
    @(negedge clk);
    check_irq("R7 counter read leaves irq");
    wait_to(k0 + 4 * N + HALF);
    rd(1, "R5 reload to zero");
    wait_to(k0 + 5 * N + HALF);
    rd(0, "R6 ack read returns limit");
    check_irq("R6 irq cleared by limit read");
    rd(1, "R6 reached cleared");
    wait_to(k0 + 7 * N + HALF);
    check_irq("R5 periodic match");

    // R4: limit change without restart
    wr(0, 32'h0000_0600);
    rd(0, "R4 setup limit");
    wait_to(k0 + N + HALF);
    wr(2, 32'h0000_0C00);
    wait_to(k0 + 3 * N + HALF);
    rd(1, "R4 count kept past old limit");
    check_irq("R4 no match at old limit");
    wait_to(k0 + 6 * N + HALF);
    check_irq("R4 match at new limit");
    rd(1, "R4 count at new limit");
    wait_to(k0 + 7 * N + HALF);
    rd(1, "R4 reload after new limit");

    // R9: undefined words
    wr(1, 32'h1234_5600);
    wr(5, 32'h7FFF_FE00);
    wait_to(k0 + 9 * N + HALF);
    rd(1, "R9 count unaffected by ignored writes");
    rd(3, "R9 word 3 reads zero");
    rd(7, "R9 word 7 reads zero");
    rd(2, "R9 word 2 reads zero");
    rd(0, "R9 limit unchanged");
    wait_to(k0 + 13 * N + HALF);
    check_irq("R5 periodic match after ack");

    // R3 deassert and R8 free-run
    wr(0, 32'h0000_0000);
    check_irq("R3 irq dropped by limit write");
    rd(0, "R8 zero limit readback");
    for (int i = 1; i <= 12; i++) begin
      wait_to(k0 + i * N + HALF);
      check_irq("R8 no irq with zero limit");
    end
    rd(1, "R8 free-run count");

    // R10: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(1, "R10 held response data");
    check_eq("R10 rsp_valid after read", {31'b0, rsp_valid}, 32'h1);
    check_eq("R10 req_ready low while stalled", {31'b0, req_ready}, 32'h0);
    @(negedge clk);
    check_eq("R10 rsp_valid held", {31'b0, rsp_valid}, 32'h1);
    rsp_ready = 1'b1;
    @(negedge clk);
    check_eq("R10 rsp_valid dropped", {31'b0, rsp_valid}, 32'h0);
    wr(2, 32'h0000_0000);
    check_eq("R10 write gives no response", {31'b0, rsp_valid}, 32'h0);

    repeat (3) @(negedge clk);
    check_eq("R10 all responses seen", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule